// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps the per-vector message table and the pending-bit word for a device's message-signalled interrupts. A host reaches both through a 4 KiB register window over a simple valid/ready port. The device side raises requests by vector number. For each request the block either emits one message write, a 64-bit address with a 32-bit data word, or records the request as pending because the vector is masked.

Pending requests are not lost. When a table write unmasks a pending vector, that vector's message goes out at once. When the control bits are written so that the function is enabled and not function-masked, a sweep walks every vector, one per clock, and delivers whatever is pending.

Each vector also has a use counter that the device raises and lowers. A vector whose counter is zero drops its requests. When the counter reaches zero, any pending request on that vector is discarded.

Top module: `msix_vtab`

## Requirements
- R1: After reset, every implemented vector's control word reads 1 (masked). All other table words, the pending word, `ctl_enable`, `ctl_fmask` and `msg_valid` are 0.
- R2: Entry v occupies offsets 16v to 16v+15. The word at +0 holds the low address, +4 the high address, +8 the data, and +12 the control word, whose bit 0 is the mask. The control word reads back only bit 0; its other bits read as 0.
- R3: An access with `bus_full` low has no effect: a write changes nothing and a read returns 0. The register offset is `bus_addr` with bits 1:0 ignored.
- R4: The pending word sits at offset 0x800, with vector v at bit v. Host writes to it are ignored. Reads of entries at or above NVEC return 0.
- R5: A request on an unmasked vector whose use count is nonzero emits one message. Its address is {high word, low word} and its data is the data word.
- R6: A request on a vector that is masked, by its own bit or by `ctl_fmask`, sets its pending bit and emits no message.
- R7: A table write that leaves a pending vector unmasked clears that pending bit and emits the vector's message, built from the updated entry.
- R8: A control write that results in enabled and not function-masked delivers every pending, unmasked vector in ascending order and clears their pending bits.
- R9: A request with a vector index at or above NVEC, or on a vector whose use count is zero, is dropped: no message and no pending change.
- R10: A decrement that brings a use count to zero clears that vector's pending bit. A decrement at zero leaves the count at zero.
- R11: If a request and a decrement to zero hit the same vector in the same cycle, the pending bit ends up clear.
- R12: While `msg_valid` is high and `msg_ready` is low, the message holds steady and `irq_ready` stays low.
- R13: A read accepted at one clock edge returns `rd_valid` high with its data after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Host access request |
| bus_ready | output | 1 | Host access accepted this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_full | input | 1 | 1 = full 32-bit access |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| ctl_we | input | 1 | Control bits write strobe |
| ctl_enable_wr | input | 1 | Enable value to write |
| ctl_fmask_wr | input | 1 | Function-mask value to write |
| ctl_enable | output | 1 | Enable bit |
| ctl_fmask | output | 1 | Function-wide mask bit |
| irq_valid | input | 1 | Device request |
| irq_ready | output | 1 | Request accepted this cycle |
| irq_vec | input | IDXW | Requested vector |
| use_inc | input | 1 | Raise use count |
| use_dec | input | 1 | Lower use count |
| use_vec | input | IDXW | Vector for use update |
| msg_valid | output | 1 | Message write pending on output |
| msg_ready | input | 1 | Message taken |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
A device request and a use-count decrement are independent inputs and can land on the same vector in the same clock. The bench drives `irq_valid` and `use_dec` together for a masked vector whose count is one. It then reads the pending word and expects that bit clear, in contrast to the same request alone, which leaves the bit set. A second overlap, a control write that starts the sweep while the message output is stalled, is judged by the ordered message queue and by `irq_ready` staying low.

// File: rtl/msix_vtab.sv
module msix_vtab #(
  parameter int NVEC = 8,
  parameter int IDXW = 5,
  parameter int UCW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  output logic            bus_ready,
  input  logic            bus_write,
  input  logic            bus_full,
  input  logic [11:0]     bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic            rd_valid,
  output logic [31:0]     rd_data,
  input  logic            ctl_we,
  input  logic            ctl_enable_wr,
  input  logic            ctl_fmask_wr,
  output logic            ctl_enable,
  output logic            ctl_fmask,
  input  logic            irq_valid,
  output logic            irq_ready,
  input  logic [IDXW-1:0] irq_vec,
  input  logic            use_inc,
  input  logic            use_dec,
  input  logic [IDXW-1:0] use_vec,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [63:0]     msg_addr,
  output logic [31:0]     msg_data
);
  localparam int VW = (NVEC > 1) ? $clog2(NVEC) : 1;
  localparam logic [UCW-1:0] UMAX = {UCW{1'b1}};

  logic [31:0]    t_lo [NVEC];
  logic [31:0]    t_hi [NVEC];
  logic [31:0]    t_dat[NVEC];
  logic [UCW-1:0] ucnt [NVEC];
  logic [NVEC-1:0] t_mask, pend;
  logic           sweep_on;
  logic [VW-1:0]  sweep_idx;

  // host decode
  wire         in_tab = !bus_addr[11];
  wire [7:0]   ent    = bus_addr[11:4];
  wire [1:0]   wsel   = bus_addr[3:2];
  wire         ent_ok = in_tab && (ent < 8'(NVEC));
  wire [VW-1:0] ev    = ent[VW-1:0];

  assign bus_ready = !msg_valid && !sweep_on;
  assign irq_ready = !msg_valid && !sweep_on && !bus_valid;

  wire acc    = bus_valid && bus_ready;
  wire wr_hit = acc && bus_write && bus_full && ent_ok;

  // table write with re-evaluation of the addressed vector
  wire [31:0] n_lo   = (wsel == 2'd0) ? bus_wdata : t_lo[ev];
  wire [31:0] n_hi   = (wsel == 2'd1) ? bus_wdata : t_hi[ev];
  wire [31:0] n_dat  = (wsel == 2'd2) ? bus_wdata : t_dat[ev];
  wire        n_mask = (wsel == 2'd3) ? bus_wdata[0] : t_mask[ev];
  wire        wr_send = wr_hit && !ctl_fmask && !n_mask && pend[ev];

  // device requests
  wire [VW-1:0] iv      = irq_vec[VW-1:0];
  wire          irq_acc = irq_valid && irq_ready;
  wire          irq_ok  = (irq_vec < IDXW'(NVEC)) && (ucnt[iv] != '0);
  wire          irq_msk = ctl_fmask || t_mask[iv];
  wire          irq_send = irq_acc && irq_ok && !irq_msk;
  wire          irq_pend = irq_acc && irq_ok && irq_msk;

  // sweep
  wire sw_step = sweep_on && !msg_valid;
  wire sw_send = sw_step && pend[sweep_idx] && !ctl_fmask && !t_mask[sweep_idx];
  wire sw_go   = ctl_we && ctl_enable_wr && !ctl_fmask_wr;

  // use counters
  wire [VW-1:0] uv     = use_vec[VW-1:0];
  wire          u_in   = use_vec < IDXW'(NVEC);
  wire          u_up   = u_in && use_inc && !use_dec;
  wire          u_dn   = u_in && use_dec && !use_inc;
  wire          u_zero = u_dn && (ucnt[uv] == UCW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NVEC; v++) begin
        t_lo[v]  <= '0;
        t_hi[v]  <= '0;
        t_dat[v] <= '0;
        ucnt[v]  <= '0;
      end
      t_mask <= '1;
      pend   <= '0;
    end else begin
      if (wr_hit) begin
        t_lo[ev]   <= n_lo;
        t_hi[ev]   <= n_hi;
        t_dat[ev]  <= n_dat;
        t_mask[ev] <= n_mask;
      end
      if (u_up && ucnt[uv] != UMAX) ucnt[uv] <= ucnt[uv] + UCW'(1);
      if (u_dn && ucnt[uv] != '0)   ucnt[uv] <= ucnt[uv] - UCW'(1);
      for (int v = 0; v < NVEC; v++) begin
        if (irq_pend && iv == VW'(v)) pend[v] <= 1'b1;
        if (wr_send && ev == VW'(v)) pend[v] <= 1'b0;
        if (sw_send && sweep_idx == VW'(v)) pend[v] <= 1'b0;
        if (u_zero && uv == VW'(v)) pend[v] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_enable <= 1'b0;
      ctl_fmask  <= 1'b0;
      sweep_on   <= 1'b0;
      sweep_idx  <= '0;
    end else begin
      if (ctl_we) begin
        ctl_enable <= ctl_enable_wr;
        ctl_fmask  <= ctl_fmask_wr;
      end
      if (sw_step) begin
        sweep_idx <= sweep_idx + VW'(1);
        if (sweep_idx == VW'(NVEC - 1)) sweep_on <= 1'b0;
      end
      if (sw_go) begin
        sweep_on  <= 1'b1;
        sweep_idx <= '0;
      end
    end
  end

  // message output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      if (msg_valid && msg_ready) msg_valid <= 1'b0;
      if (irq_send) begin
        msg_valid <= 1'b1;
        msg_addr  <= {t_hi[iv], t_lo[iv]};
        msg_data  <= t_dat[iv];
      end else if (wr_send) begin
        msg_valid <= 1'b1;
        msg_addr  <= {n_hi, n_lo};
        msg_data  <= n_dat;
      end else if (sw_send) begin
        msg_valid <= 1'b1;
        msg_addr  <= {t_hi[sweep_idx], t_lo[sweep_idx]};
        msg_data  <= t_dat[sweep_idx];
      end
    end
  end

  // read path
  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (bus_full) begin
      if (ent_ok) begin
        case (wsel)
          2'd0: rd_val = t_lo[ev];
          2'd1: rd_val = t_hi[ev];
          2'd2: rd_val = t_dat[ev];
          default: rd_val = {31'b0, t_mask[ev]};
        endcase
      end else if (!in_tab && bus_addr[10:2] == 9'd0) begin
        rd_val = 32'(pend);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc && !bus_write;
      if (acc && !bus_write) rd_data <= rd_val;
    end
  end

  assert_msg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  assert_irq_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !irq_ready);

  assert_read_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && !bus_write |=> rd_valid);

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |=> !msg_valid);

  assert_range_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ready && irq_vec >= IDXW'(NVEC) |=> !msg_valid);

  assert_zero_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    u_zero |=> !pend[$past(uv)]);
endmodule

// File: tb/msix_vtab_bench.sv
`timescale 1ns/100ps
module msix_vtab_bench;
  localparam int NVEC = 8;
  localparam int IDXW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 0, bus_write = 0, bus_full = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, rd_valid, ctl_enable, ctl_fmask, irq_ready, msg_valid;
  logic [31:0] rd_data, msg_data;
  logic [63:0] msg_addr;
  logic ctl_we = 0, ctl_enable_wr = 0, ctl_fmask_wr = 0;
  logic irq_valid = 0, use_inc = 0, use_dec = 0, msg_ready = 1;
  logic [IDXW-1:0] irq_vec = '0, use_vec = '0;

  int checks = 0, errors = 0;
  logic [95:0] expq[$];

  always #2.5 clk = ~clk;

  msix_vtab #(.NVEC(NVEC), .IDXW(IDXW), .UCW(3)) u_msix_vtab (
    .clk, .rst_n, .bus_valid, .bus_ready, .bus_write, .bus_full, .bus_addr,
    .bus_wdata, .rd_valid, .rd_data, .ctl_we, .ctl_enable_wr, .ctl_fmask_wr,
    .ctl_enable, .ctl_fmask, .irq_valid, .irq_ready, .irq_vec, .use_inc,
    .use_dec, .use_vec, .msg_valid, .msg_ready, .msg_addr, .msg_data);

  function automatic logic [31:0] lo_of(int v);  return 32'h1000_0000 + 32'(v * 16); endfunction
  function automatic logic [31:0] hi_of(int v);  return 32'h0000_00A0 + 32'(v);      endfunction
  function automatic logic [31:0] dat_of(int v); return 32'h0000_D000 + 32'(v);      endfunction

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_msg(int v);
    expq.push_back({hi_of(v), lo_of(v), dat_of(v)});
  endtask

  // monitor: pops expected messages as they leave the block
  initial forever begin
    @(negedge clk); #1;
    if (rst_n && msg_valid && msg_ready) begin
      if (expq.size() == 0) chk("R5 unexpected message", {msg_addr, msg_data}, '0);
      else chk("R5 message", {msg_addr, msg_data}, expq.pop_front());
    end
  end

  task automatic bus_acc(input logic wr, input logic full, input logic [11:0] a,
                         input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_full = full; bus_addr = a; bus_wdata = d;
    forever begin #1; if (bus_ready) break; @(negedge clk); end
    @(posedge clk); #1;
    bus_valid = 0;
    @(negedge clk);
    q = rd_data;
    if (!wr) chk("R13 rd_valid", 96'(rd_valid), 96'(1));
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] q;
    bus_acc(1'b1, 1'b1, a, d, q);
  endtask

  task automatic rd_chk(string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] q;
    bus_acc(1'b0, 1'b1, a, 32'h0, q);
    chk(req, 96'(q), 96'(exp));
  endtask

  task automatic irq(input int v, input logic with_dec);
    @(negedge clk);
    irq_valid = 1; irq_vec = IDXW'(v);
    if (with_dec) begin use_dec = 1; use_vec = IDXW'(v); end
    forever begin #1; if (irq_ready) break; @(negedge clk); end
    @(posedge clk); #1;
    irq_valid = 0; use_dec = 0;
  endtask

  task automatic use_op(input int v, input logic up);
    @(negedge clk);
    use_vec = IDXW'(v); use_inc = up; use_dec = !up;
    @(posedge clk); #1;
    use_inc = 0; use_dec = 0;
  endtask

  task automatic ctl(input logic en, input logic fm);
    @(negedge clk);
    ctl_we = 1; ctl_enable_wr = en; ctl_fmask_wr = fm;
    @(posedge clk); #1;
    ctl_we = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 outputs", {93'b0, ctl_enable, ctl_fmask, msg_valid}, '0);
    rd_chk("R1 vec0 ctrl", 12'h00C, 32'd1);
    rd_chk("R1 vec7 ctrl", 12'h07C, 32'd1);
    rd_chk("R1 vec3 lo", 12'h030, 32'd0);
    rd_chk("R1 pending", 12'h800, 32'd0);

    // R2 layout
    for (int v = 0; v < NVEC; v++) begin
      wr(12'(v * 16),     lo_of(v));
      wr(12'(v * 16 + 4), hi_of(v));
      wr(12'(v * 16 + 8), dat_of(v));
    end
    rd_chk("R2 vec2 lo", 12'h020, lo_of(2));
    rd_chk("R2 vec2 hi", 12'h024, hi_of(2));
    rd_chk("R2 vec2 data", 12'h028, dat_of(2));
    wr(12'h06C, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl bit0 only", 12'h06C, 32'd1);

    // R3 narrow access and ignored low address bits
    bus_acc(1'b1, 1'b0, 12'h010, 32'hDEAD_BEEF, q);
    rd_chk("R3 narrow write ignored", 12'h010, lo_of(1));
    bus_acc(1'b0, 1'b0, 12'h010, 32'h0, q);
    chk("R3 narrow read zero", 96'(q), '0);
    rd_chk("R3 low bits ignored", 12'h013, lo_of(1));

    // R4 pending window and out-of-range entries
    wr(12'h800, 32'hFFFF_FFFF);
    rd_chk("R4 pending write ignored", 12'h800, 32'd0);
    wr(12'h080, 32'h1234_5678);
    rd_chk("R4 entry beyond NVEC", 12'h080, 32'd0);

    for (int v = 0; v < 6; v++) use_op(v, 1'b1);
    use_op(4, 1'b1);

    // R9 drops
    wr(12'h07C, 32'd0);
    irq(7, 1'b0);
    irq(9, 1'b0);
    idle(3);
    rd_chk("R9 dropped requests leave pending", 12'h800, 32'd0);

    // R5 unmasked delivery
    wr(12'h00C, 32'd0);
    expect_msg(0);
    irq(0, 1'b0);
    idle(3);
    chk("R5 delivered", 96'(expq.size()), '0);

    // R6 masked by vector bit, then by function mask
    irq(1, 1'b0);
    rd_chk("R6 vector mask pends", 12'h800, 32'h2);
    ctl(1'b0, 1'b1);
    irq(0, 1'b0);
    idle(3);
    rd_chk("R6 function mask pends", 12'h800, 32'h3);

    // R7 unmask by table write
    ctl(1'b0, 1'b0);
    expect_msg(1);
    wr(12'h01C, 32'd0);
    idle(3);
    chk("R7 unmask delivered", 96'(expq.size()), '0);
    rd_chk("R7 pending cleared", 12'h800, 32'h1);

    // R8 sweep, with stalled output (R12)
    ctl(1'b0, 1'b1);
    wr(12'h02C, 32'd0);
    wr(12'h03C, 32'd0);
    irq(2, 1'b0);
    irq(3, 1'b0);
    rd_chk("R8 pending before sweep", 12'h800, 32'h0D);
    @(negedge clk); msg_ready = 0;
    expect_msg(0); expect_msg(2); expect_msg(3);
    ctl(1'b1, 1'b0);
    idle(3); #1;
    chk("R12 held valid", {msg_addr, 31'b0, msg_valid}, {hi_of(0), lo_of(0), 32'd1});
    irq_valid = 1; irq_vec = 5'd1;
    #0.5;
    chk("R12 irq_ready low", 96'(irq_ready), '0);
    irq_valid = 0;
    idle(2); #1;
    chk("R12 stable", {msg_addr, msg_data}, {hi_of(0), lo_of(0), dat_of(0)});
    @(negedge clk); msg_ready = 1;
    idle(20);
    chk("R8 all swept", 96'(expq.size()), '0);
    rd_chk("R8 pending cleared", 12'h800, 32'h0);

    // R10 use counter
    irq(4, 1'b0);
    use_op(4, 1'b0);
    rd_chk("R10 count one keeps pending", 12'h800, 32'h10);
    use_op(4, 1'b0);
    rd_chk("R10 zero clears pending", 12'h800, 32'h0);
    irq(4, 1'b0);
    idle(2);
    rd_chk("R10 zero count drops", 12'h800, 32'h0);
    use_op(4, 1'b0);
    use_op(4, 1'b1);
    irq(4, 1'b0);
    rd_chk("R10 dec at zero held", 12'h800, 32'h10);

    // R11 same-cycle request and decrement to zero
    irq(5, 1'b1);
    idle(2);
    rd_chk("R11 clear wins", 12'h800, 32'h10);

    idle(5);
    chk("R5 no leftover messages", 96'(expq.size()), '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule